// File: doc/BRIEF.md
# Security-Banked Interrupt CPU Interface Register File

This block holds the per-processor registers of an interrupt controller's CPU interface: the priority mask, the binary point and its aliased copy, the control word, the active-priority words for both security states, and the read-only running-priority and highest-pending views. One physical set of state is kept. Every bus access carries a secure attribute, and the block gives the secure or the non-secure view of that state. The non-secure view of priority values is the upper half of the range, shifted up by one bit, and many of its writes have no effect.

End-of-interrupt and deactivate writes pass through this block. It drops those that a non-secure agent aims at a group-0 interrupt and tags each accepted end-of-interrupt with the split-mode flag of the view it came from. The running priority and the highest-pending interrupt come in as inputs from the prioritisation logic and are read back through the banked views. Three configuration inputs select the behaviour: security extension present, architecture revision, and virtual-CPU mode.

Top module: `cpuif_bank`

## Requirements
- R1: An access is non-secure only when cfg_sec_ext_i is 1, secure_i is 0 and cfg_vcpu_i is 0. Otherwise it gets the secure view. Interrupt groups exist when cfg_rev_i equals 2 or cfg_sec_ext_i is 1.
- R2: A non-secure write to the priority mask (offset 0x04) stores 0x80 OR (data[7:0] >> 1) when stored bit 7 is 1, and changes nothing when it is 0. A secure write stores data[7:0].
- R3: A non-secure read of the priority mask returns (mask << 1) AND 0xFF when mask bit 7 is 1 and zero otherwise. A secure read returns the stored mask.
- R4: The running priority (offset 0x14) reads 0xFF when run_prio_i bit 8 is set. Otherwise a secure read returns run_prio_i[7:0]. A non-secure read returns run_prio_i[6:0] shifted left by one when bit 7 is set, and zero when it is clear.
- R5: A secure binary-point (0x08) write stores max(data[2:0], MIN_BPR). When control bit 4 (common binary point) is 1, a non-secure read returns min(secure value + 1, 7) and a non-secure write is ignored. When that bit is 0, non-secure reads and writes go to the aliased copy.
- R6: The aliased binary point (0x1C) reads zero and ignores writes when groups are absent or the access is non-secure. Every store into the aliased copy is max(data[2:0], MIN_ABPR).
- R7: A non-secure end-of-interrupt (0x10) or deactivate (0x20) write with tgt_grp1_i low produces no pulse on eoi_o or dir_o.
- R8: The highest-pending readout (0x18) returns 1023 to a non-secure reader when pend_grp1_i is 0, and pend_id_i otherwise.
- R9: Split mode is on only at revision 2, taken from control bit 10 for non-secure and bit 9 for secure access. drop_only_o equals split mode on each accepted end-of-interrupt. A deactivate write pulses dir_o only in split mode.
- R10: At 0xD0 to 0xDC, a secure access reaches the secure active-priority word and a non-secure access reaches the non-secure word of the same index. At 0xE0 to 0xEC, the non-secure word is reached by secure access only. Both windows read zero and ignore writes when the revision is not 2 or the index is NUM_APR or above.
- R11: A non-secure control (0x00) read shows bit 1 as bit 0 and bit 10 as bit 9. A non-secure write changes only those two bits (the latter only at revision 2). A secure read shows bits 0, 1, 4, 9 and 10 in place.
- R12: Read data appears on rdata_o with rvalid_o high for exactly the cycle after the read request. Undefined offsets read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_sec_ext_i | input | 1 | Security extension present |
| cfg_rev_i | input | REV_W | Architecture revision |
| cfg_vcpu_i | input | 1 | Interface serves a virtual CPU |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| secure_i | input | 1 | Access attribute: secure |
| addr_i | input | ADDR_W | Byte offset |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| rvalid_o | output | 1 | Read data valid |
| run_prio_i | input | PRIO_W+1 | Running priority, top bit means idle |
| pend_id_i | input | ID_W | Highest pending interrupt ID |
| pend_grp1_i | input | 1 | Pending interrupt is group 1 |
| tgt_grp1_i | input | 1 | Group of the ID in the current EOI/deactivate write |
| eoi_o | output | 1 | Accepted end-of-interrupt pulse |
| dir_o | output | 1 | Accepted deactivate pulse |
| done_id_o | output | ID_W | ID of the last accepted EOI/deactivate |
| drop_only_o | output | 1 | EOI drops priority only (split mode) |

## Verification
The bench builds the block with NUM_APR = 2, MIN_BPR = 2 and MIN_ABPR = 3. With two active-priority words, an in-range index (0xE4) and an out-of-range index (0xE8) inside the same window can both be tested. Because both binary-point floors are non-zero and different, each clamp can be seen on its own copy, and a write below the floor is told apart from a plain store. The default revision and security settings are switched during the run to reach the no-groups, revision-1 and virtual-CPU cases.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_PMASK = 8'h04;
  localparam logic [7:0] OFS_BPR   = 8'h08;
  localparam logic [7:0] OFS_EOI   = 8'h10;
  localparam logic [7:0] OFS_RPR   = 8'h14;
  localparam logic [7:0] OFS_HPP   = 8'h18;
  localparam logic [7:0] OFS_ABPR  = 8'h1C;
  localparam logic [7:0] OFS_DIR   = 8'h20;
  localparam logic [7:0] OFS_APR   = 8'hD0;
  localparam logic [7:0] OFS_NSAPR = 8'hE0;
  localparam logic [7:0] WIN_MASK  = 8'h0C;

  // secure view control bit positions
  localparam int CB_EN0    = 0;
  localparam int CB_EN1    = 1;
  localparam int CB_CBPR   = 4;
  localparam int CB_EOI_S  = 9;
  localparam int CB_EOI_NS = 10;
  // non-secure view control bit positions
  localparam int NV_EN1 = 0;
  localparam int NV_EOI = 9;

  typedef struct packed {
    logic ns;
    logic groups;
    logic rev2;
  } acc_ctx_t;

  typedef struct packed {
    logic s_en0;
    logic s_en1;
    logic s_cbpr;
    logic s_eoi_s;
    logic s_eoi_ns;
    logic ns_en1;
    logic ns_eoi;
  } ctrl_wr_t;
endpackage

// File: rtl/cpuif_access_qual.sv
module cpuif_access_qual #(
  parameter int REV_W     = 2,
  parameter int SPLIT_REV = 2
) (
  input  logic             sec_ext_i,
  input  logic [REV_W-1:0] rev_i,
  input  logic             vcpu_i,
  input  logic             secure_i,
  output cpuif_pkg::acc_ctx_t ctx_o
);
  assign ctx_o.rev2   = (rev_i == REV_W'(SPLIT_REV));
  assign ctx_o.groups = ctx_o.rev2 | sec_ext_i;
  // a virtual interface never exposes the security split
  assign ctx_o.ns     = sec_ext_i & ~secure_i & ~vcpu_i;
endmodule

// File: rtl/cpuif_prio_view.sv
module cpuif_prio_view #(
  parameter int PRIO_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ns_i,
  input  logic              wr_i,
  input  logic [PRIO_W-1:0] wdata_i,
  input  logic [PRIO_W:0]   run_prio_i,
  output logic [PRIO_W-1:0] pmask_rd_o,
  output logic [PRIO_W-1:0] rpr_rd_o
);
  localparam int TOP = PRIO_W - 1;

  logic [PRIO_W-1:0] mask_q;
  logic [PRIO_W-1:0] rp;
  logic              idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (wr_i) begin
      if (!ns_i)            mask_q <= wdata_i;
      else if (mask_q[TOP]) mask_q <= {1'b1, wdata_i[TOP:1]};
    end
  end

  always_comb begin
    if (!ns_i)            pmask_rd_o = mask_q;
    else if (mask_q[TOP]) pmask_rd_o = {mask_q[TOP-1:0], 1'b0};
    else                  pmask_rd_o = '0;
  end

  assign idle = run_prio_i[PRIO_W];
  assign rp   = run_prio_i[TOP:0];

  always_comb begin
    if (idle)         rpr_rd_o = '1;
    else if (!ns_i)   rpr_rd_o = rp;
    else if (rp[TOP]) rpr_rd_o = {rp[TOP-1:0], 1'b0};
    else              rpr_rd_o = '0;
  end

  AST_PMASK_NS_WI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ns_i && !mask_q[TOP]) |=> $stable(mask_q)); // R2
  AST_PMASK_NS_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ns_i && mask_q[TOP]) |=> mask_q[TOP]); // R2
endmodule

// File: rtl/cpuif_bpr_bank.sv
module cpuif_bpr_bank #(
  parameter int BP_W     = 3,
  parameter int MIN_BPR  = 0,
  parameter int MIN_ABPR = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ns_i,
  input  logic            groups_i,
  input  logic            cbpr_i,
  input  logic            wr_bpr_i,
  input  logic            wr_abpr_i,
  input  logic [BP_W-1:0] wdata_i,
  output logic [BP_W-1:0] bpr_rd_o,
  output logic [BP_W-1:0] abpr_rd_o
);
  localparam logic [BP_W-1:0] FLOOR_S = BP_W'(MIN_BPR);
  localparam logic [BP_W-1:0] FLOOR_A = BP_W'(MIN_ABPR);
  localparam logic [BP_W-1:0] BP_MAX  = '1;

  logic [BP_W-1:0] bpr_q, abpr_q;
  logic [BP_W-1:0] w_s, w_a;

  assign w_s = (wdata_i < FLOOR_S) ? FLOOR_S : wdata_i;
  assign w_a = (wdata_i < FLOOR_A) ? FLOOR_A : wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bpr_q  <= FLOOR_S;
      abpr_q <= FLOOR_A;
    end else begin
      if (wr_bpr_i) begin
        if (!ns_i)        bpr_q  <= w_s;
        else if (!cbpr_i) abpr_q <= w_a;
      end
      if (wr_abpr_i && groups_i && !ns_i) abpr_q <= w_a;
    end
  end

  always_comb begin
    if (!ns_i)              bpr_rd_o = bpr_q;
    else if (!cbpr_i)       bpr_rd_o = abpr_q;
    else if (bpr_q == BP_MAX) bpr_rd_o = BP_MAX;
    else                    bpr_rd_o = bpr_q + 1'b1;
  end

  assign abpr_rd_o = (!groups_i || ns_i) ? '0 : abpr_q;

  AST_ABPR_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abpr_q >= FLOOR_A); // R6
  AST_BPR_NS_CBPR_WI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_bpr_i && ns_i && cbpr_i) |=> ($stable(bpr_q) && $stable(abpr_q))); // R5
  AST_ABPR_NS_WI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_abpr_i && !wr_bpr_i && ns_i) |=> $stable(abpr_q)); // R6
endmodule

// File: rtl/cpuif_apr_bank.sv
module cpuif_apr_bank #(
  parameter int NUM_APR = 4,
  parameter int IDX_W   = 2,
  parameter int DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cpuif_pkg::acc_ctx_t ctx_i,
  input  logic              sel_apr_i,
  input  logic              sel_nsapr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rd_o
);
  logic [DATA_W-1:0] apr_q   [NUM_APR];
  logic [DATA_W-1:0] nsapr_q [NUM_APR];
  logic idx_ok, hit_s, hit_ns;

  assign idx_ok = int'(idx_i) < NUM_APR;
  // secure word: APR window, secure access
  assign hit_s  = sel_apr_i && ctx_i.rev2 && idx_ok && !ctx_i.ns;
  // non-secure word: APR window from NS, or NSAPR window from secure with groups
  assign hit_ns = ctx_i.rev2 && idx_ok &&
                  ((sel_apr_i && ctx_i.ns) ||
                   (sel_nsapr_i && ctx_i.groups && !ctx_i.ns));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_APR; i++) begin
        apr_q[i]   <= '0;
        nsapr_q[i] <= '0;
      end
    end else if (we_i) begin
      for (int i = 0; i < NUM_APR; i++) begin
        if (idx_i == IDX_W'(i)) begin
          if (hit_s)  apr_q[i]   <= wdata_i;
          if (hit_ns) nsapr_q[i] <= wdata_i;
        end
      end
    end
  end

  always_comb begin
    rd_o = '0;
    for (int i = 0; i < NUM_APR; i++) begin
      if (idx_i == IDX_W'(i)) begin
        if (hit_s)  rd_o = apr_q[i];
        if (hit_ns) rd_o = nsapr_q[i];
      end
    end
  end

  for (genvar g = 0; g < NUM_APR; g++) begin : g_chk
    AST_NSAPR_NS_WI: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && sel_nsapr_i && ctx_i.ns) |=> $stable(nsapr_q[g])); // R10
    AST_APR_REV_WI: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && !ctx_i.rev2) |=> ($stable(apr_q[g]) && $stable(nsapr_q[g]))); // R10
  end
endmodule

// File: rtl/cpuif_ctrl.sv
module cpuif_ctrl #(
  parameter int ID_W = 10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  cpuif_pkg::acc_ctx_t   ctx_i,
  input  logic                  wr_ctrl_i,
  input  cpuif_pkg::ctrl_wr_t   cw_i,
  input  logic                  wr_eoi_i,
  input  logic                  wr_dir_i,
  input  logic [ID_W-1:0]       id_i,
  input  logic                  tgt_grp1_i,
  output logic                  en0_o,
  output logic                  en1_o,
  output logic                  cbpr_o,
  output logic                  eoi_s_o,
  output logic                  eoi_ns_o,
  output logic                  eoi_o,
  output logic                  dir_o,
  output logic [ID_W-1:0]       done_id_o,
  output logic                  drop_only_o
);
  logic split, blocked, eoi_ok, dir_ok;

  assign split   = ctx_i.rev2 & (ctx_i.ns ? eoi_ns_o : eoi_s_o);
  assign blocked = ctx_i.ns & ~tgt_grp1_i;
  assign eoi_ok  = wr_eoi_i & ~blocked;
  assign dir_ok  = wr_dir_i & split & ~blocked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en0_o    <= 1'b0;
      en1_o    <= 1'b0;
      cbpr_o   <= 1'b0;
      eoi_s_o  <= 1'b0;
      eoi_ns_o <= 1'b0;
    end else if (wr_ctrl_i) begin
      if (ctx_i.ns) begin
        en1_o <= cw_i.ns_en1;
        if (ctx_i.rev2) eoi_ns_o <= cw_i.ns_eoi;
      end else begin
        en0_o  <= cw_i.s_en0;
        en1_o  <= cw_i.s_en1;
        cbpr_o <= cw_i.s_cbpr;
        if (ctx_i.rev2) begin
          eoi_s_o  <= cw_i.s_eoi_s;
          eoi_ns_o <= cw_i.s_eoi_ns;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eoi_o       <= 1'b0;
      dir_o       <= 1'b0;
      drop_only_o <= 1'b0;
      done_id_o   <= '0;
    end else begin
      eoi_o       <= eoi_ok;
      dir_o       <= dir_ok;
      drop_only_o <= eoi_ok & split;
      if (eoi_ok || dir_ok) done_id_o <= id_i;
    end
  end

  AST_EOI_NS_GRP0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_o |-> !$past(ctx_i.ns && !tgt_grp1_i)); // R7
  AST_DIR_NS_GRP0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_o |-> !$past(ctx_i.ns && !tgt_grp1_i)); // R7
  AST_SPLIT_REV2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_o || drop_only_o) |-> $past(ctx_i.rev2)); // R9
  AST_CTRL_NS_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl_i && ctx_i.ns) |=> ($stable(en0_o) && $stable(cbpr_o) && $stable(eoi_s_o))); // R11
endmodule

// File: rtl/cpuif_bank.sv
module cpuif_bank #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int REV_W    = 2,
  parameter int PRIO_W   = 8,
  parameter int ID_W     = 10,
  parameter int BP_W     = 3,
  parameter int NUM_APR  = 4,
  parameter int MIN_BPR  = 0,
  parameter int MIN_ABPR = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_sec_ext_i,
  input  logic [REV_W-1:0]  cfg_rev_i,
  input  logic              cfg_vcpu_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              secure_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  input  logic [PRIO_W:0]   run_prio_i,
  input  logic [ID_W-1:0]   pend_id_i,
  input  logic              pend_grp1_i,
  input  logic              tgt_grp1_i,
  output logic              eoi_o,
  output logic              dir_o,
  output logic [ID_W-1:0]   done_id_o,
  output logic              drop_only_o
);
  import cpuif_pkg::*;

  localparam int IDX_W = 2;
  localparam logic [ADDR_W-1:0] WIN_M = ~ADDR_W'(WIN_MASK);
  localparam logic [ID_W-1:0]   SPURIOUS = '1;

  acc_ctx_t ctx;
  ctrl_wr_t cw;
  logic wr, rd;
  logic sel_ctrl, sel_pmask, sel_bpr, sel_eoi, sel_rpr, sel_hpp, sel_abpr, sel_dir;
  logic sel_apr, sel_nsapr;
  logic en0, en1, cbpr, eoi_s, eoi_ns;
  logic [PRIO_W-1:0] pmask_rd, rpr_rd;
  logic [BP_W-1:0]   bpr_rd, abpr_rd;
  logic [DATA_W-1:0] apr_rd, ctrl_rd, rd_mux;
  logic [ID_W-1:0]   hpp_rd;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  assign sel_ctrl  = addr_i == ADDR_W'(OFS_CTRL);
  assign sel_pmask = addr_i == ADDR_W'(OFS_PMASK);
  assign sel_bpr   = addr_i == ADDR_W'(OFS_BPR);
  assign sel_eoi   = addr_i == ADDR_W'(OFS_EOI);
  assign sel_rpr   = addr_i == ADDR_W'(OFS_RPR);
  assign sel_hpp   = addr_i == ADDR_W'(OFS_HPP);
  assign sel_abpr  = addr_i == ADDR_W'(OFS_ABPR);
  assign sel_dir   = addr_i == ADDR_W'(OFS_DIR);
  assign sel_apr   = (addr_i & WIN_M) == ADDR_W'(OFS_APR);
  assign sel_nsapr = (addr_i & WIN_M) == ADDR_W'(OFS_NSAPR);

  cpuif_access_qual #(.REV_W(REV_W), .SPLIT_REV(2)) i_qual (
    .sec_ext_i (cfg_sec_ext_i),
    .rev_i     (cfg_rev_i),
    .vcpu_i    (cfg_vcpu_i),
    .secure_i  (secure_i),
    .ctx_o     (ctx)
  );

  cpuif_prio_view #(.PRIO_W(PRIO_W)) i_prio (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ns_i       (ctx.ns),
    .wr_i       (wr & sel_pmask),
    .wdata_i    (wdata_i[PRIO_W-1:0]),
    .run_prio_i (run_prio_i),
    .pmask_rd_o (pmask_rd),
    .rpr_rd_o   (rpr_rd)
  );

  cpuif_bpr_bank #(.BP_W(BP_W), .MIN_BPR(MIN_BPR), .MIN_ABPR(MIN_ABPR)) i_bpr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ns_i      (ctx.ns),
    .groups_i  (ctx.groups),
    .cbpr_i    (cbpr),
    .wr_bpr_i  (wr & sel_bpr),
    .wr_abpr_i (wr & sel_abpr),
    .wdata_i   (wdata_i[BP_W-1:0]),
    .bpr_rd_o  (bpr_rd),
    .abpr_rd_o (abpr_rd)
  );

  cpuif_apr_bank #(.NUM_APR(NUM_APR), .IDX_W(IDX_W), .DATA_W(DATA_W)) i_apr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctx_i       (ctx),
    .sel_apr_i   (sel_apr),
    .sel_nsapr_i (sel_nsapr),
    .idx_i       (addr_i[IDX_W+1:2]),
    .we_i        (wr),
    .wdata_i     (wdata_i),
    .rd_o        (apr_rd)
  );

  assign cw.s_en0    = wdata_i[CB_EN0];
  assign cw.s_en1    = wdata_i[CB_EN1];
  assign cw.s_cbpr   = wdata_i[CB_CBPR];
  assign cw.s_eoi_s  = wdata_i[CB_EOI_S];
  assign cw.s_eoi_ns = wdata_i[CB_EOI_NS];
  assign cw.ns_en1   = wdata_i[NV_EN1];
  assign cw.ns_eoi   = wdata_i[NV_EOI];

  cpuif_ctrl #(.ID_W(ID_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctx_i       (ctx),
    .wr_ctrl_i   (wr & sel_ctrl),
    .cw_i        (cw),
    .wr_eoi_i    (wr & sel_eoi),
    .wr_dir_i    (wr & sel_dir),
    .id_i        (wdata_i[ID_W-1:0]),
    .tgt_grp1_i  (tgt_grp1_i),
    .en0_o       (en0),
    .en1_o       (en1),
    .cbpr_o      (cbpr),
    .eoi_s_o     (eoi_s),
    .eoi_ns_o    (eoi_ns),
    .eoi_o       (eoi_o),
    .dir_o       (dir_o),
    .done_id_o   (done_id_o),
    .drop_only_o (drop_only_o)
  );

  always_comb begin
    ctrl_rd = '0;
    if (ctx.ns) begin
      ctrl_rd[NV_EN1] = en1;
      ctrl_rd[NV_EOI] = eoi_ns;
    end else begin
      ctrl_rd[CB_EN0]    = en0;
      ctrl_rd[CB_EN1]    = en1;
      ctrl_rd[CB_CBPR]   = cbpr;
      ctrl_rd[CB_EOI_S]  = eoi_s;
      ctrl_rd[CB_EOI_NS] = eoi_ns;
    end
  end

  assign hpp_rd = (ctx.groups && ctx.ns && !pend_grp1_i) ? SPURIOUS : pend_id_i;

  always_comb begin
    rd_mux = '0;
    if (sel_ctrl)                rd_mux = ctrl_rd;
    else if (sel_pmask)          rd_mux = DATA_W'(pmask_rd);
    else if (sel_bpr)            rd_mux = DATA_W'(bpr_rd);
    else if (sel_rpr)            rd_mux = DATA_W'(rpr_rd);
    else if (sel_hpp)            rd_mux = DATA_W'(hpp_rd);
    else if (sel_abpr)           rd_mux = DATA_W'(abpr_rd);
    else if (sel_apr | sel_nsapr) rd_mux = apr_rd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd;
      if (rd) rdata_o <= rd_mux;
    end
  end

  AST_RVALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && !we_i)); // R12
  AST_RVALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o); // R12
endmodule

// File: tb/test_cpuif_bank.sv
module test_cpuif_bank;
  typedef struct packed {
    logic        we;
    logic        sec;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 57;
  // sec_ext=1, rev=2, vcpu=0 throughout the table
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,8'h04,32'h0,32'h00,4'd3},          // R3 reset mask
    '{1'b1,1'b1,8'h04,32'h40,32'h0,4'd2},
    '{1'b0,1'b0,8'h04,32'h0,32'h00,4'd3},          // R3 low half RAZ
    '{1'b1,1'b0,8'h04,32'hFE,32'h0,4'd2},
    '{1'b0,1'b1,8'h04,32'h0,32'h40,4'd2},          // R2 NS write ignored
    '{1'b1,1'b1,8'h04,32'hA0,32'h0,4'd2},
    '{1'b0,1'b0,8'h04,32'h0,32'h40,4'd3},          // R3 shifted view
    '{1'b1,1'b0,8'h04,32'h30,32'h0,4'd2},
    '{1'b0,1'b1,8'h04,32'h0,32'h98,4'd2},          // R2 0x80|(0x30>>1)
    '{1'b0,1'b1,8'h08,32'h0,32'h02,4'd5},          // R5 reset floor
    '{1'b1,1'b1,8'h08,32'h0,32'h0,4'd5},
    '{1'b0,1'b1,8'h08,32'h0,32'h02,4'd5},          // R5 clamp
    '{1'b1,1'b1,8'h08,32'h5,32'h0,4'd5},
    '{1'b0,1'b1,8'h08,32'h0,32'h05,4'd5},
    '{1'b0,1'b0,8'h08,32'h0,32'h03,4'd5},          // R5 NS sees alias
    '{1'b1,1'b0,8'h08,32'h1,32'h0,4'd6},
    '{1'b0,1'b0,8'h08,32'h0,32'h03,4'd6},          // R6 alias floor
    '{1'b1,1'b0,8'h08,32'h6,32'h0,4'd5},
    '{1'b0,1'b0,8'h08,32'h0,32'h06,4'd5},
    '{1'b0,1'b1,8'h08,32'h0,32'h05,4'd5},          // R5 secure copy kept
    '{1'b0,1'b1,8'h1C,32'h0,32'h06,4'd6},          // R6
    '{1'b0,1'b0,8'h1C,32'h0,32'h00,4'd6},          // R6 NS RAZ
    '{1'b1,1'b0,8'h1C,32'h4,32'h0,4'd6},
    '{1'b0,1'b1,8'h1C,32'h0,32'h06,4'd6},          // R6 NS WI
    '{1'b1,1'b1,8'h1C,32'h0,32'h0,4'd6},
    '{1'b0,1'b1,8'h1C,32'h0,32'h03,4'd6},          // R6 clamp
    '{1'b1,1'b1,8'h00,32'h13,32'h0,4'd11},
    '{1'b0,1'b1,8'h00,32'h0,32'h13,4'd11},         // R11
    '{1'b0,1'b0,8'h00,32'h0,32'h01,4'd11},         // R11 NS view
    '{1'b0,1'b0,8'h08,32'h0,32'h06,4'd5},          // R5 cbpr: 5+1
    '{1'b1,1'b0,8'h08,32'h2,32'h0,4'd5},
    '{1'b0,1'b0,8'h08,32'h0,32'h06,4'd5},          // R5 cbpr WI
    '{1'b0,1'b1,8'h1C,32'h0,32'h03,4'd5},
    '{1'b1,1'b1,8'h08,32'h7,32'h0,4'd5},
    '{1'b0,1'b0,8'h08,32'h0,32'h07,4'd5},          // R5 saturate at 7
    '{1'b1,1'b0,8'h00,32'hFFFFFFFF,32'h0,4'd11},
    '{1'b0,1'b1,8'h00,32'h0,32'h413,4'd11},        // R11 NS write mask
    '{1'b0,1'b0,8'h00,32'h0,32'h201,4'd11},
    '{1'b1,1'b0,8'h00,32'h0,32'h0,4'd11},
    '{1'b0,1'b1,8'h00,32'h0,32'h11,4'd11},
    '{1'b1,1'b1,8'hD0,32'h11,32'h0,4'd10},
    '{1'b0,1'b1,8'hD0,32'h0,32'h11,4'd10},         // R10
    '{1'b1,1'b1,8'hE0,32'h22,32'h0,4'd10},
    '{1'b0,1'b1,8'hE0,32'h0,32'h22,4'd10},
    '{1'b0,1'b0,8'hE0,32'h0,32'h00,4'd10},         // R10 NS RAZ
    '{1'b1,1'b0,8'hE0,32'h55,32'h0,4'd10},
    '{1'b0,1'b1,8'hE0,32'h0,32'h22,4'd10},         // R10 NS WI
    '{1'b0,1'b0,8'hD0,32'h0,32'h22,4'd10},         // R10 NS alias
    '{1'b1,1'b0,8'hD0,32'h33,32'h0,4'd10},
    '{1'b0,1'b1,8'hE0,32'h0,32'h33,4'd10},
    '{1'b0,1'b1,8'hD0,32'h0,32'h11,4'd10},
    '{1'b1,1'b1,8'hE8,32'h77,32'h0,4'd10},
    '{1'b0,1'b1,8'hE8,32'h0,32'h00,4'd10},         // R10 index out of range
    '{1'b1,1'b1,8'hE4,32'h44,32'h0,4'd10},
    '{1'b0,1'b1,8'hE4,32'h0,32'h44,4'd10},
    '{1'b1,1'b1,8'h40,32'hDEAD,32'h0,4'd12},
    '{1'b0,1'b1,8'h40,32'h0,32'h00,4'd12}          // R12 undefined offset
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_ext = 1'b1;
  logic [1:0] rev = 2'd2;
  logic vcpu = 1'b0;
  logic req = 1'b0, we = 1'b0, sec = 1'b1;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic rvalid;
  logic [8:0] run_prio = 9'h1FF;
  logic [9:0] pend_id = '0;
  logic pend_grp1 = 1'b0, tgt_grp1 = 1'b0;
  logic eoi, dir, drop_only;
  logic [9:0] done_id;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  cpuif_bank #(.NUM_APR(2), .MIN_BPR(2), .MIN_ABPR(3)) i_cpuif_bank (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_sec_ext_i(sec_ext), .cfg_rev_i(rev), .cfg_vcpu_i(vcpu),
    .req_i(req), .we_i(we), .secure_i(sec), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rvalid_o(rvalid),
    .run_prio_i(run_prio), .pend_id_i(pend_id), .pend_grp1_i(pend_grp1),
    .tgt_grp1_i(tgt_grp1),
    .eoi_o(eoi), .dir_o(dir), .done_id_o(done_id), .drop_only_o(drop_only)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic s, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; sec = s; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic s, input logic [7:0] a, input logic [31:0] exp);
    bus(1'b0, s, a, '0);
    chk({tag, " rvalid"}, {31'b0, rvalid}, 32'd1);
    chk(tag, rdata, exp);
  endtask

  task automatic eoi_chk(input string tag, input logic s, input logic [7:0] a, input logic [9:0] id,
                         input logic g1, input logic e_eoi, input logic e_dir, input logic e_drop);
    tgt_grp1 = g1;
    bus(1'b1, s, a, {22'b0, id});
    chk({tag, " eoi"}, {31'b0, eoi}, {31'b0, e_eoi});
    chk({tag, " dir"}, {31'b0, dir}, {31'b0, e_dir});
    chk({tag, " drop"}, {31'b0, drop_only}, {31'b0, e_drop});
    if (e_eoi || e_dir) chk({tag, " id"}, {22'b0, done_id}, {22'b0, id});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset rvalid", {31'b0, rvalid}, 32'd0);
    chk("R12 reset rdata", rdata, 32'd0);
    chk("R7 reset eoi", {31'b0, eoi}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      bus(VECS[i].we, VECS[i].sec, VECS[i].addr, VECS[i].data);
      if (!VECS[i].we) begin
        n_chk++;
        if (rdata !== VECS[i].exp || rvalid !== 1'b1) begin
          n_fail++;
          $display("FAIL R%0d vec %0d actual=%h expected=%h", VECS[i].req, i, rdata, VECS[i].exp);
        end
      end else begin
        chk("R12 no rvalid on write", {31'b0, rvalid}, 32'd0);
      end
    end

    // R4 running priority views
    run_prio = 9'h1FF;
    rd_chk("R4 idle secure", 1'b1, 8'h14, 32'hFF);
    rd_chk("R4 idle ns", 1'b0, 8'h14, 32'hFF);
    run_prio = 9'h0C3;
    rd_chk("R4 secure", 1'b1, 8'h14, 32'hC3);
    rd_chk("R4 ns upper", 1'b0, 8'h14, 32'h86);
    run_prio = 9'h043;
    rd_chk("R4 ns lower", 1'b0, 8'h14, 32'h00);
    rd_chk("R4 secure lower", 1'b1, 8'h14, 32'h43);

    // R8 highest pending
    pend_id = 10'd5; pend_grp1 = 1'b0;
    rd_chk("R8 ns grp0 spurious", 1'b0, 8'h18, 32'd1023);
    rd_chk("R8 secure grp0", 1'b1, 8'h18, 32'd5);
    pend_grp1 = 1'b1;
    rd_chk("R8 ns grp1", 1'b0, 8'h18, 32'd5);
    pend_grp1 = 1'b0;

    // R7 / R9 completion gating; ctrl now 0x11 (split off both views)
    eoi_chk("R7 ns eoi grp0", 1'b0, 8'h10, 10'h25, 1'b0, 1'b0, 1'b0, 1'b0);
    eoi_chk("R7 secure eoi grp0", 1'b1, 8'h10, 10'h25, 1'b0, 1'b1, 1'b0, 1'b0);
    eoi_chk("R9 ns eoi no split", 1'b0, 8'h10, 10'h30, 1'b1, 1'b1, 1'b0, 1'b0);
    eoi_chk("R9 ns dir no split", 1'b0, 8'h20, 10'h30, 1'b1, 1'b0, 1'b0, 1'b0);
    bus(1'b1, 1'b0, 8'h00, 32'h200);
    eoi_chk("R9 ns eoi split", 1'b0, 8'h10, 10'h31, 1'b1, 1'b1, 1'b0, 1'b1);
    eoi_chk("R9 ns dir split", 1'b0, 8'h20, 10'h32, 1'b1, 1'b0, 1'b1, 1'b0);
    eoi_chk("R7 ns dir grp0", 1'b0, 8'h20, 10'h33, 1'b0, 1'b0, 1'b0, 1'b0);
    eoi_chk("R9 secure dir bit9 clear", 1'b1, 8'h20, 10'h34, 1'b0, 1'b0, 1'b0, 1'b0);
    eoi_chk("R9 secure eoi bit9 clear", 1'b1, 8'h10, 10'h35, 1'b0, 1'b1, 1'b0, 1'b0);
    rev = 2'd1;
    eoi_chk("R9 rev1 ns eoi", 1'b0, 8'h10, 10'h36, 1'b1, 1'b1, 1'b0, 1'b0);
    eoi_chk("R9 rev1 ns dir", 1'b0, 8'h20, 10'h37, 1'b1, 1'b0, 1'b0, 1'b0);
    rd_chk("R10 rev1 nsapr RAZ", 1'b1, 8'hE0, 32'h0);
    rd_chk("R10 rev1 apr RAZ", 1'b1, 8'hD0, 32'h0);
    rev = 2'd2;

    // R1 qualification
    vcpu = 1'b1;
    rd_chk("R1 vcpu ns attr secure view", 1'b0, 8'h1C, 32'h3);
    rd_chk("R1 vcpu pmask secure view", 1'b0, 8'h04, 32'h98);
    vcpu = 1'b0;
    rd_chk("R1 ns attr", 1'b0, 8'h1C, 32'h0);
    sec_ext = 1'b0;
    rd_chk("R1 no sec ext groups via rev2", 1'b0, 8'h1C, 32'h3);
    rev = 2'd1;
    rd_chk("R6 no groups RAZ", 1'b1, 8'h1C, 32'h0);
    bus(1'b1, 1'b1, 8'h1C, 32'h6);
    rev = 2'd2;
    rd_chk("R6 no groups WI", 1'b1, 8'h1C, 32'h3);
    rev = 2'd1;
    rd_chk("R8 no groups id passes", 1'b0, 8'h18, 32'd5);
    rev = 2'd2; sec_ext = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule